// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block keeps a small mailbox for every processor in a system. Each mailbox entry holds two 64-bit interrupt payload words, a busy flag and the id of the sender. An interrupt sender fills an entry in one cycle through a dedicated delivery port. The payload words are written, the flag is raised and the sender id is recorded at the same time. Processors then inspect and acknowledge their mailbox over a simple 64-bit register bus.

Every mailbox register can be reached in two ways. The first is an indexed array whose offset names the entry with an 8-byte stride. The second is a fixed alias offset. An alias access reaches the entry that belongs to the requester, using a processor id that comes with each bus access, so software does not need to know its own index. A bus write to a flag register changes only the flag. Payload words can be read but not written from the bus. Offsets that hit no register are reported as errors. Every access gets a registered response one cycle later.

Top module: `irq_mailbox`

## Requirements
- R1: After reset, every busy flag and sender id is 0, and `rsp_valid` is 0 until the first access.
- R2: Every bus access gives exactly one response, one cycle later: `rsp_valid` is high in the cycle after `bus_valid` and low otherwise. Payload word 0 of entry i is read at offset 0x000 + 8*i, and payload word 1 at offset 0x100 + 8*i (defaults: 32 entries).
- R3: A read at alias offset 0x300 returns payload word 0 of entry `bus_cpu`. A read at 0x308 returns payload word 1 of that entry.
- R4: Flag registers sit at offset 0x200 + 8*i, with alias 0x310 resolved by `bus_cpu`. A read returns the busy flag in bit 5 and the sender id in bits 4:0, with all other bits 0.
- R5: A delivery with `dlv_valid` high stores `dlv_word0` and `dlv_word1`, sets busy and records `dlv_src` in entry `dlv_target`.
- R6: A bus write to a flag register, indexed or alias, sets the busy flag to data bit 5. The sender id does not change.
- R7: A bus write to a payload-word offset changes nothing and is not an error. Every write response carries 0 as data.
- R8: A read or write at an offset that hits no register gives `rsp_err` = 1 with response data 0. This includes alias offsets off by a few bytes and anything at 0x318 or above. Mapped accesses give `rsp_err` = 0.
- R9: If a delivery and a bus flag write target the same entry in the same cycle, the delivery wins and the flag ends up set. If they target different entries, both take effect.
- R10: A read in the same cycle as a delivery to the same entry returns the contents from before that delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_cpu | input | log2(NUM_ENTRIES) | Id of the requesting processor, used by alias offsets |
| dlv_valid | input | 1 | Delivery strobe |
| dlv_target | input | log2(NUM_ENTRIES) | Entry to deliver into |
| dlv_src | input | SRC_W | Sender id to record |
| dlv_word0 | input | DATA_W | Payload word 0 |
| dlv_word1 | input | DATA_W | Payload word 1 |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Access hit no register |
| rsp_rdata | output | DATA_W | Read data (0 on writes and errors) |

## Verification
The bench checks that alias offsets follow `bus_cpu` and not the address bits. A design that mixed these up would return entry 0 or the wrong entry's payload. It writes flag registers with junk in the low bits to show that the sender id survives. A design that copied the whole field would overwrite it with data bits 4:0. It also targets the same entry with a delivery and a flag-clearing write in one cycle, where a wrong priority would leave the flag low. It reads an entry while it is being delivered into, which shows whether a design forwards new data too early. Offsets just past the alias registers and writes to payload words are aimed at a decoder that either flags too much or silently accepts what it should report.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Register kind chosen by the address decoder
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_WORD0 = 2'd1,
    K_WORD1 = 2'd2,
    K_FLAG  = 2'd3
  } kind_e;

  // Bit of a flag register that carries the busy flag
  localparam int FLAG_BIT = 5;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  cpu,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int SPAN = NUM_ENTRIES * 8;
  localparam logic [ADDR_W-1:0] W0_BASE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] W1_BASE  = ADDR_W'(SPAN);
  localparam logic [ADDR_W-1:0] FL_BASE  = ADDR_W'(2 * SPAN);
  localparam logic [ADDR_W-1:0] AL_W0    = ADDR_W'(3 * SPAN);
  localparam logic [ADDR_W-1:0] AL_W1    = ADDR_W'(3 * SPAN + 8);
  localparam logic [ADDR_W-1:0] AL_FLAG  = ADDR_W'(3 * SPAN + 16);
  localparam logic [ADDR_W-1:0] SPAN_A   = ADDR_W'(SPAN);

  logic [ADDR_W-1:0] off0, off1, offf;

  always_comb begin
    off0 = addr - W0_BASE;
    off1 = addr - W1_BASE;
    offf = addr - FL_BASE;
    kind = K_NONE;
    idx  = '0;
    if (addr < W1_BASE) begin
      kind = K_WORD0;
      idx  = off0[IDX_W+2:3];
    end else if (addr < FL_BASE) begin
      kind = K_WORD1;
      idx  = off1[IDX_W+2:3];
    end else if (offf < SPAN_A) begin
      kind = K_FLAG;
      idx  = offf[IDX_W+2:3];
    end else if (addr == AL_W0) begin
      kind = K_WORD0;
      idx  = cpu;
    end else if (addr == AL_W1) begin
      kind = K_WORD1;
      idx  = cpu;
    end else if (addr == AL_FLAG) begin
      kind = K_FLAG;
      idx  = cpu;
    end
  end
endmodule

// File: rtl/mbx_word_ram.sv
module mbx_word_ram #(
  parameter int DEPTH      = 32,
  parameter int WIDTH      = 64,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Single write port, registered read: old data on a same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_flag_file.sv
module mbx_flag_file #(
  parameter int NUM_ENTRIES = 32,
  parameter int SRC_W       = 5,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dlv_valid,
  input  logic [IDX_W-1:0] dlv_idx,
  input  logic [SRC_W-1:0] dlv_src,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_busy,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_busy,
  output logic [SRC_W-1:0] rd_src
);
  logic [NUM_ENTRIES-1:0] busy_q;
  logic [SRC_W-1:0]       src_q [NUM_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= '0;
      rd_busy <= 1'b0;
      rd_src  <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) src_q[i] <= '0;
    end else begin
      rd_busy <= busy_q[rd_idx];
      rd_src  <= src_q[rd_idx];
      // bus flag write first, so a delivery to the same entry overrides it
      if (wr_en) busy_q[wr_idx] <= wr_busy;
      if (dlv_valid) begin
        busy_q[dlv_idx] <= 1'b1;
        src_q[dlv_idx]  <= dlv_src;
      end
    end
  end

  p_deliver_sets_r5: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |=> busy_q[$past(dlv_idx)] && src_q[$past(dlv_idx)] == $past(dlv_src));

  p_flag_write_keeps_src_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(dlv_valid && dlv_idx == wr_idx))
      |=> busy_q[$past(wr_idx)] == $past(wr_busy)
          && src_q[$past(wr_idx)] == $past(src_q[wr_idx]));

  p_deliver_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && wr_en && dlv_idx == wr_idx) |=> busy_q[$past(wr_idx)]);
endmodule

// File: rtl/irq_mailbox.sv
module irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int DATA_W      = 64,
  parameter int SRC_W       = 5,
  parameter int ADDR_W      = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [$clog2(NUM_ENTRIES)-1:0] bus_cpu,
  input  logic                           dlv_valid,
  input  logic [$clog2(NUM_ENTRIES)-1:0] dlv_target,
  input  logic [SRC_W-1:0]               dlv_src,
  input  logic [DATA_W-1:0]              dlv_word0,
  input  logic [DATA_W-1:0]              dlv_word1,
  output logic                           rsp_valid,
  output logic                           rsp_err,
  output logic [DATA_W-1:0]              rsp_rdata
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  kind_e             kind;
  kind_e             sel_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] dlv_words [2];
  logic [DATA_W-1:0] ram_q [2];
  logic              flag_busy;
  logic [SRC_W-1:0]  flag_src;
  logic              flag_wr;

  mbx_decode #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .cpu  (bus_cpu),
    .kind (kind),
    .idx  (idx)
  );

  assign dlv_words[0] = dlv_word0;
  assign dlv_words[1] = dlv_word1;

  // One inferable RAM per payload word; the bus never writes them
  for (genvar g = 0; g < 2; g++) begin : g_word
    mbx_word_ram #(.DEPTH(NUM_ENTRIES), .WIDTH(DATA_W)) u_ram (
      .clk   (clk),
      .we    (dlv_valid),
      .waddr (dlv_target),
      .wdata (dlv_words[g]),
      .raddr (idx),
      .rdata (ram_q[g])
    );
  end

  assign flag_wr = bus_valid && bus_write && (kind == K_FLAG);

  mbx_flag_file #(.NUM_ENTRIES(NUM_ENTRIES), .SRC_W(SRC_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .dlv_valid (dlv_valid),
    .dlv_idx   (dlv_target),
    .dlv_src   (dlv_src),
    .wr_en     (flag_wr),
    .wr_idx    (idx),
    .wr_busy   (bus_wdata[FLAG_BIT]),
    .rd_idx    (idx),
    .rd_busy   (flag_busy),
    .rd_src    (flag_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      sel_q     <= K_NONE;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid && (kind == K_NONE);
      sel_q     <= (bus_valid && !bus_write) ? kind : K_NONE;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    case (sel_q)
      K_WORD0: rsp_rdata = ram_q[0];
      K_WORD1: rsp_rdata = ram_q[1];
      K_FLAG: begin
        rsp_rdata[FLAG_BIT]  = flag_busy;
        rsp_rdata[SRC_W-1:0] = flag_src;
      end
      default: rsp_rdata = '0;
    endcase
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !rsp_valid);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid && !rsp_err);
  p_err_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid && rsp_rdata == '0);
  p_write_zero_data_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write) |=> rsp_rdata == '0);
endmodule

// File: tb/sim_irq_mailbox.sv
`timescale 1ns/1ps
module sim_irq_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [4:0]  bus_cpu = '0;
  logic        dlv_valid = 1'b0;
  logic [4:0]  dlv_target = '0;
  logic [4:0]  dlv_src = '0;
  logic [63:0] dlv_word0 = '0, dlv_word1 = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_mailbox u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .dlv_valid(dlv_valid), .dlv_target(dlv_target), .dlv_src(dlv_src),
    .dlv_word0(dlv_word0), .dlv_word1(dlv_word1),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one access (optionally together with a prepared delivery);
  // the registered response is sampled at the next falling edge.
  task automatic access(input logic wr, input logic [11:0] a, input logic [63:0] d,
                        input logic [4:0] cpu, input logic with_dlv,
                        output logic e, output logic [63:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_cpu = cpu;
    dlv_valid = with_dlv;
    @(negedge clk);
    bus_valid = 1'b0; dlv_valid = 1'b0;
    check("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    e = rsp_err;
    q = rsp_rdata;
  endtask

  task automatic set_dlv(input logic [4:0] t, input logic [4:0] s,
                         input logic [63:0] w0, input logic [63:0] w1);
    dlv_target = t; dlv_src = s; dlv_word0 = w0; dlv_word1 = w1;
  endtask

  task automatic deliver(input logic [4:0] t, input logic [4:0] s,
                         input logic [63:0] w0, input logic [63:0] w1);
    @(negedge clk);
    set_dlv(t, s, w0, w1);
    dlv_valid = 1'b1;
    @(negedge clk);
    dlv_valid = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [4:0] cpu,
                    input logic [63:0] exp);
    logic e;
    logic [63:0] q;
    access(1'b0, a, 64'd0, cpu, 1'b0, e, q);
    check(req, q, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [4:0] cpu);
    logic e;
    logic [63:0] q;
    access(1'b1, a, d, cpu, 1'b0, e, q);
  endtask

  localparam int NV = 12;
  localparam logic        T_WR   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1};
  localparam logic [11:0] T_ADDR [NV] = '{12'h000, 12'h028, 12'h1F8, 12'h300, 12'h308, 12'h228,
                                          12'h310, 12'h208, 12'h318, 12'h400, 12'h304, 12'h028};
  localparam logic [4:0]  T_CPU  [NV] = '{0, 0, 0, 5, 31, 0, 31, 0, 0, 0, 0, 0};
  localparam logic        T_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0};
  localparam logic [63:0] T_EXP  [NV] = '{64'h1111_0000_0000_0000, 64'h1111_0000_0000_0005,
                                          64'h2222_0000_0000_001F, 64'h1111_0000_0000_0005,
                                          64'h2222_0000_0000_001F, 64'h31, 64'h3F, 64'h0,
                                          64'h0, 64'h0, 64'h0, 64'h0};
  localparam logic [15:0] T_REQ  [NV] = '{"R2", "R2", "R2", "R3", "R3", "R4",
                                          "R4", "R4", "R8", "R8", "R8", "R7"};

  initial begin
    logic e;
    logic [63:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd("R1 flag entry 0", 12'h200, 5'd0, 64'h0);
    rd("R1 alias flag cpu 31", 12'h310, 5'd31, 64'h0);

    deliver(5'd0, 5'd3, 64'h1111_0000_0000_0000, 64'h2222_0000_0000_0000);
    deliver(5'd5, 5'd17, 64'h1111_0000_0000_0005, 64'h2222_0000_0000_0005);
    deliver(5'd31, 5'd31, 64'h1111_0000_0000_001F, 64'h2222_0000_0000_001F);
    rd("R5 alias flag cpu 0 after delivery", 12'h310, 5'd0, 64'h23);

    for (int i = 0; i < NV; i++) begin
      access(T_WR[i], T_ADDR[i], T_WR[i] ? 64'hFFFF : 64'h0, T_CPU[i], 1'b0, e, q);
      check({T_REQ[i], " table err"}, 64'(e), 64'(T_ERR[i]));
      check({T_REQ[i], " table data"}, q, T_EXP[i]);
    end

    // R7: the ignored payload write left the word intact
    rd("R7 payload after bus write", 12'h028, 5'd0, 64'h1111_0000_0000_0005);
    @(negedge clk);
    check("R2 idle rsp_valid", 64'(rsp_valid), 64'd0);

    // R6: flag writes touch only the busy flag
    wr(12'h228, 64'h0, 5'd0);
    rd("R6 indexed clear keeps source", 12'h228, 5'd0, 64'h11);
    wr(12'h310, 64'h0, 5'd31);
    rd("R6 alias clear keeps source", 12'h310, 5'd31, 64'h1F);
    wr(12'h310, 64'hFFFF_FFFF_FFFF_FFE0, 5'd31);
    rd("R6 alias set with junk low bits", 12'h310, 5'd31, 64'h3F);
    wr(12'h208, 64'h3F, 5'd0);
    rd("R6 source stays 0", 12'h208, 5'd0, 64'h20);

    // R9: delivery and flag write in one cycle
    set_dlv(5'd7, 5'd9, 64'h7, 64'h70);
    access(1'b1, 12'h238, 64'h0, 5'd0, 1'b1, e, q);
    rd("R9 same entry delivery wins", 12'h238, 5'd0, 64'h29);
    set_dlv(5'd8, 5'd2, 64'h8, 64'h80);
    access(1'b1, 12'h208, 64'h0, 5'd0, 1'b1, e, q);
    rd("R9 other entry write applies", 12'h208, 5'd0, 64'h0);
    rd("R9 other entry delivery applies", 12'h240, 5'd0, 64'h22);

    // R10: read during delivery to the same entry sees old contents
    set_dlv(5'd0, 5'd4, 64'h3333_0000_0000_0000, 64'h4444_0000_0000_0000);
    access(1'b0, 12'h000, 64'h0, 5'd0, 1'b1, e, q);
    check("R10 word read during delivery", q, 64'h1111_0000_0000_0000);
    rd("R10 word read after delivery", 12'h000, 5'd0, 64'h3333_0000_0000_0000);
    rd("R10 word1 after delivery", 12'h100, 5'd0, 64'h4444_0000_0000_0000);
    set_dlv(5'd1, 5'd6, 64'h1, 64'h10);
    access(1'b0, 12'h208, 64'h0, 5'd0, 1'b1, e, q);
    check("R10 flag read during delivery", q, 64'h0);
    rd("R10 flag read after delivery", 12'h208, 5'd0, 64'h26);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule